// File: doc/BRIEF.md
# Codec Start-Up and Power-Down Sequencer

This block controls when the digital section of a voice-band codec is allowed to drive its converter outputs. It reacts to three things: a supply-good flag from an external voltage detector, an active-low power-down pin, and the number of system clocks that have elapsed. After power is good, or after the power-down pin is released, it runs an initialization window counted in system clocks. It then releases the two converter paths separately, using hold times counted in sample periods.

While the sequencer is initializing or powered down, the DAC output is pulled to ground and the ADC serial output is kept in high impedance. After initialization, the DAC output sits at mid-scale for a fixed number of sample periods before it follows real data. The ADC output stays disabled for a longer, separate number of sample periods. The mode pins of the codec are captured at the moment each initialization starts, so the rest of the chip sees a configuration that only changes across a reset. A sample period is `CLK_PER_SAMPLE` system clocks, timed by a divider that is cleared when initialization starts.

All timings below assume the default of two synchronizer stages on `vdd_ok` and `pd_n`. The defaults are: `INIT_CYCLES` = 1024 clocks, `CLK_PER_SAMPLE` = 512, `DAC_HOLD_SAMPLES` = 2048, `ADC_HOLD_SAMPLES` = 2304, `PD_MIN_LOW` = 1 and `PRE_CLKS` = 3.

Top module: `codec_pwr_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `dac_gnd` = 1, `dac_mid` = 0, `adc_oe` = 0 and `mode_q` = 0.
- R2: A power-on start needs `PRE_CLKS` clocks counted while the synchronized `vdd_ok` is low. If `vdd_ok` is already high at reset release, the block stays in its waiting state with `dac_gnd` = 1 and `adc_oe` = 0 until `vdd_ok` has been low long enough and rises again.
- R3: Initialization lasts `INIT_CYCLES` clocks, with `dac_gnd` = 1, `dac_mid` = 0 and `adc_oe` = 0. When it starts from power-down, `dac_gnd` is first seen low after the (`INIT_CYCLES`+4)th rising edge, counting from the first edge that samples `pd_n` high.
- R4: Right after initialization, `dac_mid` = 1 and `dac_gnd` = 0 for exactly `DAC_HOLD_SAMPLES`×`CLK_PER_SAMPLE` clocks. `dac_mid` then falls to 0.
- R5: `adc_oe` rises exactly `ADC_HOLD_SAMPLES`×`CLK_PER_SAMPLE` clocks after initialization ends. It then stays at 1 during normal operation.
- R6: `dac_gnd` and `dac_mid` are never both 1, and `adc_oe` is never 1 together with `dac_gnd`.
- R7: If `pd_n` is sampled low for `PD_MIN_LOW` or more consecutive clocks, the block enters power-down, with `dac_gnd` = 1, `dac_mid` = 0 and `adc_oe` = 0. These values appear after the (`PD_MIN_LOW`+3)th edge from the first low sample, and they hold for as long as `pd_n` stays low. The later rise of `pd_n` starts a full initialization.
- R8: A low pulse on `pd_n` that is shorter than `PD_MIN_LOW` clocks has no effect. `adc_oe` stays 1, `dac_gnd` stays 0 and `mode_q` keeps its value.
- R9: After reset the power-down input is treated as asserted until it is seen high. With `pd_n` held low through power-on, the block stays powered down indefinitely, and the first rise of `pd_n` starts initialization.
- R10: `mode_q` captures `mode_pins` on the clock edge that starts an initialization, and holds that value at all other times.
- R11: A fall of `vdd_ok` in any state returns the block to waiting, with `dac_gnd` = 1 and `adc_oe` = 0 within four clocks. A later rise of `vdd_ok` starts a full initialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (512 × sample rate by default) |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer logic |
| vdd_ok | input | 1 | Supply-above-threshold flag, asynchronous |
| pd_n | input | 1 | Active-low power-down/reset request, asynchronous |
| mode_pins | input | MODE_W | Configuration pins to capture at initialization start |
| dac_gnd | output | 1 | Force the DAC output to ground |
| dac_mid | output | 1 | Force the DAC output to mid-scale |
| adc_oe | output | 1 | Enable the ADC serial data output (0 = high impedance) |
| mode_q | output | MODE_W | Captured configuration |

## Verification
The assertions assume that `ADC_HOLD_SAMPLES` is not smaller than `DAC_HOLD_SAMPLES`, so the ADC is never enabled while the DAC is still held at mid-scale. They also assume that `vdd_ok` and `pd_n` change only as whole-clock levels, so each pulse reaches the filter as a count of clocks and never as a sub-cycle glitch. The stimulus drives every input on the falling clock edge and sizes every `pd_n` pulse in whole cycles. It tests pulse lengths on both sides of the `PD_MIN_LOW` threshold, and it never releases the chip while the sequencer is in the middle of a settle that the assertions would count as complete.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;
  typedef enum logic [2:0] {
    SEQ_WAIT   = 3'd0,
    SEQ_DOWN   = 3'd1,
    SEQ_INIT   = 3'd2,
    SEQ_SETTLE = 3'd3,
    SEQ_RUN    = 3'd4
  } seq_state_e;
endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cps_pd_filter.sv
module cps_pd_filter #(
  parameter int MIN_LOW = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_s,
  output logic up_lvl
);
  localparam int CW = (MIN_LOW < 2) ? 1 : $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);

  logic [CW-1:0] low_cnt;

  // Level resets to "powered down": an undriven input must not release the codec.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      up_lvl  <= 1'b0;
    end else if (pd_s) begin
      low_cnt <= '0;
      up_lvl  <= 1'b1;
    end else begin
      if (low_cnt == LAST) up_lvl <= 1'b0;
      else                 low_cnt <= low_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cps_por_gate.sv
module cps_por_gate #(
  parameter int PRE_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vdd_s,
  output logic por_go
);
  localparam int PW = $clog2(PRE_CLKS + 1);
  localparam logic [PW-1:0] FULL = PW'(PRE_CLKS);

  logic [PW-1:0] pre_cnt;

  // Clocks are only credited while the supply is still below threshold.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pre_cnt <= '0;
    else if (!vdd_s && pre_cnt != FULL)  pre_cnt <= pre_cnt + 1'b1;
  end

  assign por_go = vdd_s && (pre_cnt == FULL);
endmodule

// File: rtl/cps_timer.sv
module cps_timer #(
  parameter int INIT_CYCLES      = 1024,
  parameter int CLK_PER_SAMPLE   = 512,
  parameter int DAC_HOLD_SAMPLES = 2048,
  parameter int ADC_HOLD_SAMPLES = 2304
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_init,
  input  logic in_settle,
  output logic init_last,
  output logic dac_done,
  output logic adc_done,
  output logic settle_done
);
  localparam int MAXH = (DAC_HOLD_SAMPLES > ADC_HOLD_SAMPLES) ? DAC_HOLD_SAMPLES : ADC_HOLD_SAMPLES;
  localparam int IW   = $clog2(INIT_CYCLES);
  localparam int DW   = $clog2(CLK_PER_SAMPLE);
  localparam int SW   = $clog2(MAXH + 1);
  localparam logic [IW-1:0] I_LAST = IW'(INIT_CYCLES - 1);
  localparam logic [DW-1:0] D_LAST = DW'(CLK_PER_SAMPLE - 1);
  localparam logic [SW-1:0] S_MAX  = SW'(MAXH);

  logic [IW-1:0] init_cnt;
  logic [DW-1:0] div_cnt;
  logic [SW-1:0] samp_cnt;
  logic          tick;

  assign tick = (div_cnt == D_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt <= '0;
      div_cnt  <= '0;
      samp_cnt <= '0;
    end else if (start) begin
      init_cnt <= '0;
      div_cnt  <= '0;
      samp_cnt <= '0;
    end else begin
      if (in_init || in_settle) div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (in_init && init_cnt != I_LAST) init_cnt <= init_cnt + 1'b1;
      if (in_settle && tick && samp_cnt != S_MAX) samp_cnt <= samp_cnt + 1'b1;
    end
  end

  assign init_last   = in_init && (init_cnt == I_LAST);
  assign dac_done    = (samp_cnt >= SW'(DAC_HOLD_SAMPLES));
  assign adc_done    = (samp_cnt >= SW'(ADC_HOLD_SAMPLES));
  assign settle_done = (samp_cnt == S_MAX);
endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
  import codec_pwr_pkg::*;
#(
  parameter int INIT_CYCLES      = 1024,
  parameter int CLK_PER_SAMPLE   = 512,
  parameter int DAC_HOLD_SAMPLES = 2048,
  parameter int ADC_HOLD_SAMPLES = 2304,
  parameter int PD_MIN_LOW       = 1,
  parameter int PRE_CLKS         = 3,
  parameter int SYNC_STAGES      = 2,
  parameter int MODE_W           = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vdd_ok,
  input  logic              pd_n,
  input  logic [MODE_W-1:0] mode_pins,
  output logic              dac_gnd,
  output logic              dac_mid,
  output logic              adc_oe,
  output logic [MODE_W-1:0] mode_q
);
  seq_state_e st, nxt;
  logic vdd_s, pd_s, up_lvl, por_go;
  logic start, init_last, dac_done, adc_done, settle_done;

  cps_sync #(.STAGES(SYNC_STAGES)) u_vdd_sync (.clk(clk), .rst_n(rst_n), .d(vdd_ok), .q(vdd_s));
  cps_sync #(.STAGES(SYNC_STAGES)) u_pd_sync  (.clk(clk), .rst_n(rst_n), .d(pd_n),   .q(pd_s));

  cps_pd_filter #(.MIN_LOW(PD_MIN_LOW)) u_filt (
    .clk(clk), .rst_n(rst_n), .pd_s(pd_s), .up_lvl(up_lvl)
  );

  cps_por_gate #(.PRE_CLKS(PRE_CLKS)) u_por (
    .clk(clk), .rst_n(rst_n), .vdd_s(vdd_s), .por_go(por_go)
  );

  cps_timer #(
    .INIT_CYCLES(INIT_CYCLES), .CLK_PER_SAMPLE(CLK_PER_SAMPLE),
    .DAC_HOLD_SAMPLES(DAC_HOLD_SAMPLES), .ADC_HOLD_SAMPLES(ADC_HOLD_SAMPLES)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_init(st == SEQ_INIT), .in_settle(st == SEQ_SETTLE),
    .init_last(init_last), .dac_done(dac_done), .adc_done(adc_done),
    .settle_done(settle_done)
  );

  always_comb begin
    nxt = st;
    case (st)
      SEQ_WAIT:   if (por_go) nxt = up_lvl ? SEQ_INIT : SEQ_DOWN;
      SEQ_DOWN:   if (up_lvl) nxt = SEQ_INIT;
      SEQ_INIT:   if (init_last) nxt = SEQ_SETTLE;
      SEQ_SETTLE: if (settle_done) nxt = SEQ_RUN;
      default:    nxt = st;
    endcase
    // Supply loss outranks everything; power-down outranks the active phases.
    if (st != SEQ_WAIT && !vdd_s)
      nxt = SEQ_WAIT;
    else if ((st == SEQ_INIT || st == SEQ_SETTLE || st == SEQ_RUN) && !up_lvl)
      nxt = SEQ_DOWN;
  end

  assign start = (nxt == SEQ_INIT) && (st != SEQ_INIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SEQ_WAIT;
    else        st <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= '0;
    else if (start) mode_q <= mode_pins;
  end

  assign dac_gnd = (st == SEQ_WAIT) || (st == SEQ_DOWN) || (st == SEQ_INIT);
  assign dac_mid = (st == SEQ_SETTLE) && !dac_done;
  assign adc_oe  = (st == SEQ_RUN) || ((st == SEQ_SETTLE) && adc_done);
endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
  parameter int INIT_CYCLES      = 1024,
  parameter int CLK_PER_SAMPLE   = 512,
  parameter int DAC_HOLD_SAMPLES = 2048,
  parameter int ADC_HOLD_SAMPLES = 2304,
  parameter int MODE_W           = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dac_gnd,
  input logic              dac_mid,
  input logic              adc_oe,
  input logic [MODE_W-1:0] mode_q
);
  localparam int MID_LEN = DAC_HOLD_SAMPLES * CLK_PER_SAMPLE;
  localparam int GW = $clog2(INIT_CYCLES + 2);
  localparam int MW = $clog2(MID_LEN + 2);

  logic [GW-1:0] gnd_run;
  logic [MW-1:0] mid_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnd_run <= '0;
      mid_run <= '0;
    end else begin
      if (!dac_gnd) gnd_run <= '0;
      else if (gnd_run != GW'(INIT_CYCLES)) gnd_run <= gnd_run + 1'b1;
      if (!dac_mid) mid_run <= '0;
      else if (mid_run != MW'(MID_LEN + 1)) mid_run <= mid_run + 1'b1;
    end
  end

  assert_gnd_mid_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(dac_gnd && dac_mid));

  assert_oe_not_gnd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_oe |-> !dac_gnd);

  assert_init_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_gnd) |-> (gnd_run >= GW'(INIT_CYCLES)));

  assert_gnd_into_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_gnd) |-> dac_mid);

  assert_mid_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dac_mid) && !dac_gnd) |-> (mid_run == MW'(MID_LEN)));

  assert_mode_only_in_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> $past(dac_gnd));

  generate
    if (ADC_HOLD_SAMPLES >= DAC_HOLD_SAMPLES) begin : g_order
      assert_adc_after_dac_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_oe) |-> !dac_mid);
    end
  endgenerate
endmodule

bind codec_pwr_seq cps_checker #(
  .INIT_CYCLES(INIT_CYCLES), .CLK_PER_SAMPLE(CLK_PER_SAMPLE),
  .DAC_HOLD_SAMPLES(DAC_HOLD_SAMPLES), .ADC_HOLD_SAMPLES(ADC_HOLD_SAMPLES),
  .MODE_W(MODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dac_gnd(dac_gnd), .dac_mid(dac_mid),
  .adc_oe(adc_oe), .mode_q(mode_q)
);

// File: tb/sim_codec_pwr_seq.sv
module sim_codec_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int INIT = 16;
  localparam int CPS  = 4;
  localparam int DH   = 5;
  localparam int AH   = 7;
  localparam int PDMIN = 3;
  localparam int MW   = 3;
  // {len[7:4], mode[3:1], restart[0]}
  localparam logic [7:0] VEC [0:5] = '{8'h14, 8'h26, 8'h3D, 8'h53, 8'h2E, 8'h89};

  logic clk, rst_n, vdd_ok, pd_n;
  logic [MW-1:0] mode_pins, mode_q;
  logic dac_gnd, dac_mid, adc_oe;
  int tests = 0, fails = 0, excl_viol = 0;

  codec_pwr_seq #(
    .INIT_CYCLES(INIT), .CLK_PER_SAMPLE(CPS), .DAC_HOLD_SAMPLES(DH),
    .ADC_HOLD_SAMPLES(AH), .PD_MIN_LOW(PDMIN), .PRE_CLKS(3),
    .SYNC_STAGES(2), .MODE_W(MW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .vdd_ok(vdd_ok), .pd_n(pd_n), .mode_pins(mode_pins),
    .dac_gnd(dac_gnd), .dac_mid(dac_mid), .adc_oe(adc_oe), .mode_q(mode_q)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  always @(negedge clk)
    if (rst_n && ((dac_gnd && dac_mid) || (adc_oe && dac_gnd))) excl_viol++;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_run(input int limit, output int ok);
    ok = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (adc_oe) begin ok = 1; break; end
    end
  endtask

  // Called at a falling edge right after pd_n was raised from power-down.
  task automatic measure_release(input string tag);
    int n, m, a;
    n = 0;
    while (n < 200) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (!dac_gnd) break;
    end
    chk({"R3 init latency ", tag}, n, INIT + 4);
    m = 0;
    while (dac_mid && m < 1000) begin m++; @(negedge clk); end
    chk({"R4 mid-scale hold ", tag}, m, DH * CPS);
    a = m;
    while (!adc_oe && a < 1000) begin a++; @(negedge clk); end
    chk({"R5 adc release ", tag}, a, AH * CPS);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog R5 actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int ok, bad, n;
    logic [MW-1:0] prev;
    rst_n = 1'b0; vdd_ok = 1'b0; pd_n = 1'b1; mode_pins = 3'b101;
    repeat (3) @(negedge clk);
    chk("R1 gnd in reset", dac_gnd, 1);
    chk("R1 oe in reset", adc_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 gnd after reset", dac_gnd, 1);
    chk("R1 mid after reset", dac_mid, 0);
    chk("R1 mode after reset", mode_q, 0);

    // power-on start
    repeat (5) @(negedge clk);
    vdd_ok = 1'b1;
    wait_run(200, ok);
    chk("R5 power-on reaches run", ok, 1);
    chk("R10 mode captured at power-on", mode_q, 3'b101);

    // table of pd_n pulses
    for (int v = 0; v < 6; v++) begin
      int len;
      logic restart;
      len = int'(VEC[v][7:4]);
      restart = VEC[v][0];
      prev = mode_q;
      mode_pins = VEC[v][3:1];
      pd_n = 1'b0;
      bad = 0;
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        if (!adc_oe || dac_gnd) bad++;
      end
      pd_n = 1'b1;
      if (!restart) begin
        for (int i = 0; i < 12; i++) begin
          @(negedge clk);
          if (!adc_oe || dac_gnd) bad++;
        end
        chk("R8 short pulse ignored", bad, 0);
        chk("R8 mode kept after short pulse", mode_q, prev);
      end else begin
        n = 0;
        for (int i = 0; i < 20; i++) begin
          @(negedge clk);
          if (dac_gnd) n = 1;
        end
        chk("R7 long pulse forces outputs", n, 1);
        wait_run(200, ok);
        chk("R7 restart reaches run", ok, 1);
        chk("R10 mode captured on restart", mode_q, VEC[v][3:1]);
      end
    end

    // power-down latency and full release timing
    pd_n = 1'b0;
    n = 0;
    while (n < 50) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (!adc_oe) break;
    end
    chk("R7 power-down latency", n, PDMIN + 3);
    chk("R7 gnd in power-down", dac_gnd, 1);
    repeat (30) @(negedge clk);
    chk("R7 still down while low", adc_oe, 0);
    mode_pins = 3'b011;
    pd_n = 1'b1;
    measure_release("after pd");
    chk("R10 mode after pd release", mode_q, 3'b011);
    mode_pins = 3'b110;
    repeat (5) @(negedge clk);
    chk("R10 mode holds in run", mode_q, 3'b011);

    // supply drop
    vdd_ok = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 gnd on supply loss", dac_gnd, 1);
    chk("R11 oe on supply loss", adc_oe, 0);
    repeat (20) @(negedge clk);
    chk("R11 stays waiting", dac_gnd, 1);
    vdd_ok = 1'b1;
    wait_run(200, ok);
    chk("R11 restart after supply return", ok, 1);
    chk("R10 mode after supply return", mode_q, 3'b110);

    // supply already high at reset release: no start
    rst_n = 1'b0; vdd_ok = 1'b1; pd_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    chk("R2 no start without pre-clocks gnd", dac_gnd, 1);
    chk("R2 no start without pre-clocks oe", adc_oe, 0);
    vdd_ok = 1'b0;
    repeat (5) @(negedge clk);
    vdd_ok = 1'b1;
    wait_run(200, ok);
    chk("R2 start after supply cycles", ok, 1);

    // power-down pin low through power-on
    rst_n = 1'b0; vdd_ok = 1'b0; pd_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    vdd_ok = 1'b1;
    repeat (200) @(negedge clk);
    chk("R9 held down gnd", dac_gnd, 1);
    chk("R9 held down oe", adc_oe, 0);
    pd_n = 1'b1;
    measure_release("from power-on down");

    chk("R6 exclusive forced states", excl_viol, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule